// File: doc/BRIEF.md
# Paged Byte-Write Sequencer for a Parallel EEPROM

This block is the internal write engine of a byte-alterable parallel EEPROM. A host on a synchronous bus with active-low chip select, write strobe and output enable, a 15-bit byte address and 8-bit data loads between one and 128 bytes into a page buffer. All bytes in one load must fall in the same 128-byte page. The load closes on its own when no further byte strobe starts inside a load window. The block then enters a self-timed programming phase and copies the buffered bytes into a behavioural memory array.

While programming runs there is no busy pin. The host polls by reading. A read of the most recently written address returns that byte with its top bit inverted. On every read, bit 6 changes value from one read to the next. Once programming ends, reads return true array data and bit 6 holds still.

The load window (`WIN_CYC`) and the programming time (`PROG_CYC`) are counted in clock cycles. A simulation can therefore use short values.

The behavioural array keeps `MEM_AW` low address bits, which is 2048 bytes by default. Higher address bits alias onto it. `PROG_CYC` must exceed the page size, because the array receives one buffered byte per cycle at the start of programming.

Top module: `eeprom_page_wseq`

## Requirements
- R1: A write strobe is recognised only in cycles where `cs_n` and `we_n` are both 0 and `oe_n` is 1. A strobe with `oe_n` at 0 neither opens a load nor changes any byte.
- R2: The byte address is taken in the first cycle of a strobe. The data is the value of `din` in the last cycle of the strobe, so a strobe that the chip select opens and closes stores the final `din` value.
- R3: Address bits [14:7] name the page and bits [6:0] name the byte within it. A load holds up to 128 bytes of one page. If a byte offset is written twice in a load, the later value wins.
- R4: A strobe in an open load whose page bits differ from those of the load's first byte is discarded. It sets `page_err`, which stays 1 until reset.
- R5: Programming starts once `WIN_CYC` cycles have passed since the start of the last accepted strobe and no strobe is in progress. Each accepted strobe restarts that count.
- R6: During programming, a read of the last accepted address returns its data with bit 7 inverted and bits 5..0 unchanged.
- R7: During programming, bit 6 of the read data is 0 on the first read and inverts on each later read. Reads of any other address return 0 in every bit except bit 6.
- R8: Programming lasts `PROG_CYC` cycles. After it ends, every buffered byte is in the array, reads return true data, and bit 6 no longer changes between reads.
- R9: Write strobes that start during programming change neither the array nor the last accepted address.
- R10: After reset, the block is idle and `dout`, `dout_en` and `page_err` are all 0.
- R11: A read is a cycle with `cs_n` and `oe_n` both 0 and `we_n` 1. In the cycle after a read access starts, `dout_en` goes to 1 and `dout` holds the answer for the rest of that access. In the cycle after the read condition ends, `dout_en` and `dout` both return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 15 | Byte address; bits [14:7] page, bits [6:0] offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or programming status, registered |
| dout_en | output | 1 | High while `dout` carries a read answer |
| page_err | output | 1 | Sticky flag for a discarded cross-page strobe |

## Verification
The assertions check four properties on every cycle:
- `page_err` is sticky once set.
- `dout_en` follows the read condition one cycle later.
- Each programming phase spans exactly `PROG_CYC` cycles.
- Programming never begins before a full load window of quiet has passed, and no load is accepted while programming runs.

Only the bench's scenarios can show the data-dependent behaviour:
- the inverted bit 7 and the alternating bit 6 in status reads;
- which strobe value is captured when the chip select frames the strobe;
- later-wins overwrites within a page;
- discarded cross-page and mid-programming writes leaving the array untouched;
- a full 128-byte page landing intact.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ewr_state_e;
endpackage

// File: rtl/ewr_page_buf.sv
module ewr_page_buf #(
    parameter int PAGE_AW = 7,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PAGE_AW-1:0] widx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               clr,
    input  logic [PAGE_AW-1:0] ridx,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid
);
    localparam int ENTRIES = 1 << PAGE_AW;

    logic [DATA_W-1:0] slot_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (we) slot_q[widx] <= wdata;
    end

    // one valid flag per byte slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 vld_q[g] <= 1'b0;
            else if (clr)                               vld_q[g] <= 1'b0;
            else if (we && (widx == PAGE_AW'(g)))       vld_q[g] <= 1'b1;
        end
    end

    assign rdata  = slot_q[ridx];
    assign rvalid = vld_q[ridx];
endmodule

// File: rtl/ewr_cell_array.sv
module ewr_cell_array #(
    parameter int AW     = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/eeprom_page_wseq.sv
module eeprom_page_wseq
    import ewr_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int PAGE_AW  = 7,
    parameter int MEM_AW   = 11,
    parameter int WIN_CYC  = 5000,
    parameter int PROG_CYC = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              page_err
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int PG_W       = ADDR_W - PAGE_AW;
    localparam int CNT_W      = $clog2(WIN_CYC + PROG_CYC + 2);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] PAGE_CNT  = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        ewr_state_e        st;
        logic              wr_q;
        logic              rd_q;
        logic              wacc;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
        logic [PG_W-1:0]   page;
        logic [ADDR_W-1:0] last_a;
        logic [DATA_W-1:0] last_d;
        logic [CNT_W-1:0]  tmr;
        logic              tog;
        logic              err;
        logic [DATA_W-1:0] dout;
        logic              den;
    } regs_t;

    regs_t r_q, r_d;

    logic wr_act, rd_act, wr_start, wr_end;
    logic page_hit, load_go, page_bad;
    logic buf_we, buf_clr, buf_vld, cell_we, in_prog;
    logic [PAGE_AW-1:0] commit_idx;
    logic [ADDR_W-1:0]  commit_addr;
    logic [DATA_W-1:0]  buf_rdata, cell_rdata;

    // bus decode
    assign wr_act   = !cs_n && !we_n && oe_n;
    assign rd_act   = !cs_n && !oe_n && we_n;
    assign wr_start = wr_act && !r_q.wr_q;
    assign wr_end   = !wr_act && r_q.wr_q;
    assign page_hit = (addr[ADDR_W-1:PAGE_AW] == r_q.page);
    assign load_go  = wr_start && ((r_q.st == ST_IDLE) ||
                                   ((r_q.st == ST_LOAD) && page_hit));
    assign page_bad = wr_start && (r_q.st == ST_LOAD) && !page_hit;
    assign in_prog  = (r_q.st == ST_PROG);

    // buffer side: store at strobe end, drain early in programming
    assign buf_we      = wr_end && r_q.wacc;
    assign buf_clr     = in_prog && (r_q.tmr == PROG_LAST);
    assign commit_idx  = r_q.tmr[PAGE_AW-1:0];
    assign commit_addr = {r_q.page, commit_idx};
    assign cell_we     = in_prog && (r_q.tmr < PAGE_CNT) && buf_vld;

    ewr_page_buf #(
        .PAGE_AW (PAGE_AW),
        .DATA_W  (DATA_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (buf_we),
        .widx   (r_q.wa[PAGE_AW-1:0]),
        .wdata  (r_q.wd),
        .clr    (buf_clr),
        .ridx   (commit_idx),
        .rdata  (buf_rdata),
        .rvalid (buf_vld)
    );

    ewr_cell_array #(
        .AW     (MEM_AW),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk   (clk),
        .we    (cell_we),
        .waddr (commit_addr[MEM_AW-1:0]),
        .wdata (buf_rdata),
        .raddr (addr[MEM_AW-1:0]),
        .rdata (cell_rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.wr_q = wr_act;
        r_d.rd_q = rd_act;

        // data follows din while strobe is low; last value is kept
        if (wr_act)   r_d.wd   = din;
        if (wr_start) r_d.wacc = load_go;
        if (load_go)  r_d.wa   = addr;
        if (page_bad) r_d.err  = 1'b1;
        if (buf_we) begin
            r_d.last_a = r_q.wa;
            r_d.last_d = r_q.wd;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (load_go) begin
                    r_d.st   = ST_LOAD;
                    r_d.page = addr[ADDR_W-1:PAGE_AW];
                    r_d.tmr  = '0;
                end
            end
            ST_LOAD: begin
                if (load_go) begin
                    r_d.tmr = '0;
                end else if (r_q.tmr < WIN_LAST) begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end else if (!wr_act && !r_q.wr_q) begin
                    r_d.st  = ST_PROG;
                    r_d.tmr = '0;
                    r_d.tog = 1'b0;
                end
            end
            ST_PROG: begin
                if (r_q.tmr == PROG_LAST) begin
                    r_d.st  = ST_IDLE;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // read answer, captured at the start of each access
        r_d.den = rd_act;
        if (!rd_act) begin
            r_d.dout = '0;
        end else if (!r_q.rd_q) begin
            if (in_prog) begin
                r_d.tog = ~r_q.tog;
                if (addr == r_q.last_a)
                    r_d.dout = {~r_q.last_d[DATA_W-1], r_q.tog, r_q.last_d[DATA_W-3:0]};
                else
                    r_d.dout = {1'b0, r_q.tog, {(DATA_W-2){1'b0}}};
            end else begin
                r_d.dout = cell_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout     = r_q.dout;
    assign dout_en  = r_q.den;
    assign page_err = r_q.err;
endmodule

// File: rtl/ewr_chk.sv
module ewr_chk #(
    parameter int WIN_CYC  = 5000,
    parameter int PROG_CYC = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic we_n,
    input logic oe_n,
    input logic dout_en,
    input logic page_err,
    input logic in_prog,
    input logic load_go
);
    int unsigned prog_cnt_q;
    int unsigned quiet_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_cnt_q  <= 0;
            quiet_cnt_q <= 0;
        end else begin
            prog_cnt_q <= in_prog ? prog_cnt_q + 1 : 0;
            if (load_go)                     quiet_cnt_q <= 0;
            else if (quiet_cnt_q < 32'h4000_0000) quiet_cnt_q <= quiet_cnt_q + 1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err); // R4

    AST_RD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && we_n) |=> dout_en); // R11

    AST_RD_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && !oe_n && we_n) |=> !dout_en); // R11

    AST_PROG_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_prog) |-> (prog_cnt_q == PROG_CYC)); // R8

    AST_WIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_prog) |-> (quiet_cnt_q >= WIN_CYC)); // R5

    AST_NO_LOAD_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        in_prog |-> !load_go); // R9
endmodule

bind eeprom_page_wseq ewr_chk #(
    .WIN_CYC  (WIN_CYC),
    .PROG_CYC (PROG_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dout_en  (dout_en),
    .page_err (page_err),
    .in_prog  (in_prog),
    .load_go  (load_go)
);

// File: tb/eeprom_page_wseq_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_wseq_tb_top;
    localparam int WIN  = 20;
    localparam int PROG = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, page_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       den_prev = 1'b0;

    always #2 clk = ~clk;

    eeprom_page_wseq #(
        .WIN_CYC  (WIN),
        .PROG_CYC (PROG)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .din      (din),
        .dout     (dout),
        .dout_en  (dout_en),
        .page_err (page_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_we(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
        idle(2);
        we_n = 1'b1; cs_n = 1'b1;
    endtask

    // chip select frames the strobe; data changes mid-strobe
    task automatic write_ce(input logic [14:0] a, input logic [7:0] d1, input logic [7:0] d2);
        @(negedge clk);
        addr = a; oe_n = 1'b1; we_n = 1'b0; din = 8'h00;
        @(negedge clk); cs_n = 1'b0; din = d1;
        @(negedge clk); din = d2;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
    endtask

    // driver: pushes the expected answer, monitor compares it
    task automatic rd(input logic [14:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        addr = a; we_n = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
        idle(2);
        cs_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        chk(!dout_en && dout == 8'h00, "R11 release", {7'b0, dout_en}, 8'h00);
    endtask

    always @(negedge clk) begin
        if (rst_n && dout_en && !den_prev) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unrequested answer act=%h exp=none", dout);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (dout !== e) begin
                    errors++;
                    $display("FAIL %s act=%h exp=%h", t, dout, e);
                end
            end
        end
        den_prev = dout_en;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R10 reset state
        chk(dout == 8'h00, "R10 dout", dout, 8'h00);
        chk(!dout_en, "R10 dout_en", {7'b0, dout_en}, 8'h00);
        chk(!page_err, "R10 page_err", {7'b0, page_err}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // single byte, status polling during programming (R6, R7)
        write_we(15'h0123, 8'h5A);
        idle(WIN + 5);
        rd(15'h0123, 8'h9A, "R6 first poll");
        rd(15'h0123, 8'hDA, "R7 second poll toggles");
        rd(15'h0050, 8'h00, "R7 other address");
        write_we(15'h0123, 8'h11);            // R9 ignored mid-programming
        rd(15'h0123, 8'hDA, "R6 last address kept");
        idle(PROG + 20);
        rd(15'h0123, 8'h5A, "R8 true data");
        rd(15'h0123, 8'h5A, "R8 bit6 steady / R9");

        // strobe with output enable low is not a write (R1)
        @(negedge clk);
        addr = 15'h0123; din = 8'h11; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        idle(2);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        rd(15'h0123, 8'h5A, "R1 no write");
        idle(WIN + 10);
        rd(15'h0123, 8'h5A, "R1 no load opened");

        // multi-byte page with overwrite, CE-framed strobe, cross-page
        write_we(15'h0280, 8'hC3);
        idle(10);
        write_we(15'h02A5, 8'h3C);
        idle(10);
        write_we(15'h02FF, 8'h81);
        idle(10);
        write_we(15'h02A5, 8'h66);            // R3 later wins
        idle(10);
        write_ce(15'h02C0, 8'h10, 8'hE7);     // R2 final din
        idle(2);
        write_we(15'h0123, 8'hFF);            // R4 other page
        idle(2);
        chk(page_err, "R4 flag set", {7'b0, page_err}, 8'h01);
        idle(WIN + 5);
        rd(15'h02C0, 8'h27, "R6 last accepted address");
        idle(PROG + 20);
        rd(15'h0280, 8'hC3, "R3 offset 0");
        rd(15'h02A5, 8'h66, "R3 overwrite");
        rd(15'h02FF, 8'h81, "R3 offset 127");
        rd(15'h02C0, 8'hE7, "R2 data at strobe end");
        rd(15'h0123, 8'h5A, "R4 cross-page discarded");
        chk(page_err, "R4 sticky", {7'b0, page_err}, 8'h01);

        // full 128-byte page, each byte well inside the window (R3, R5)
        for (int i = 0; i < 128; i++)
            write_we(15'h0380 + 15'(i), 8'(i) ^ 8'hA5);
        idle(WIN + PROG + 20);
        for (int i = 0; i < 128; i++)
            rd(15'h0380 + 15'(i), 8'(i) ^ 8'hA5, "R3 full page");

        // window expiry splits loads; late strobe hits programming (R5, R9)
        write_we(15'h0385, 8'h00);
        idle(WIN + 4);
        write_we(15'h0386, 8'h00);
        idle(PROG + 20);
        rd(15'h0385, 8'h00, "R5 first load committed");
        rd(15'h0386, 8'hA3, "R5/R9 late strobe dropped");

        idle(4);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 missing answers act=%h exp=%h", 8'(exp_q.size()), 8'h00);
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule